// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block sits beside a small 8-bit CPU core and chooses which interrupt to take next. Each source has a pending input, an enable bit and a level bit that selects low or high priority. A global enable gates every source. On each clock the block registers the best eligible request. At an instruction boundary it then raises a vector-call request toward the core, carrying the vector address of the winning source. The core acknowledges the call with a done strobe. The core reports a return-from-interrupt with a return strobe, and it reports each completed instruction with a boundary strobe.

Two in-service bits, one for each level, give one level of nesting. A high-level request may interrupt a low-level routine. A high-level routine cannot be interrupted. A request at the same level as the routine in service waits until that routine returns. After every return, one more instruction must complete before the next vector is taken. A parameter mask selects the sources whose pending flag the block clears in hardware: for those sources the block sends a one-cycle clear pulse when the vector is issued.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, vec_req_o is 0, in_svc_o is 2'b00 (bit 1 is the high level, bit 0 the low level) and pend_clr_o is all zero.
- R2: The vector address for source n is 0x0003 + 8*n. vec_hi_o is 1 for a high-level call and 0 for a low-level call.
- R3: When enabled requests of both levels are pending in the same cycle, a high-level request is vectored first. A source is high level when its prio_hi_i bit is 1.
- R4: Among eligible requests of the same level, the lowest source index is vectored first.
- R5: A source whose en_i bit is 0, or any source while glob_en_i is 0, never raises a request and stays pending. It is vectored once it becomes enabled.
- R6: While only the low level is in service, a high-level request is vectored, and in_svc_o then becomes 2'b11.
- R7: While the high level is in service, no request of either level is vectored.
- R8: While the low level is in service, another low-level request is held until the return.
- R9: After the cycle in which reti_i is 1, the next instruction boundary does not vector. The earliest call rises on the following boundary.
- R10: vec_req_o only rises after a cycle with insn_bnd_i at 1. It then stays at 1, with a stable address, until call_done_i is seen.
- R11: When reti_i is 1, in_svc_o bit 1 is cleared if it is set; otherwise bit 0 is cleared.
- R12: For a source whose AUTO_CLR bit is 1, pend_clr_o pulses that source's bit for exactly the first cycle of the call request. For other sources pend_clr_o stays zero.
- R13: With insn_bnd_i held at 1, vec_req_o rises on the second rising edge after an eligible request becomes pending: one edge to detect it, one edge to issue it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| glob_en_i | input | 1 | Global interrupt enable |
| pend_i | input | NUM_SRC | Pending flag per source |
| en_i | input | NUM_SRC | Enable bit per source |
| prio_hi_i | input | NUM_SRC | Level bit per source, 1 = high |
| insn_bnd_i | input | 1 | Instruction-boundary strobe from the core |
| call_done_i | input | 1 | Core has taken the vector call |
| reti_i | input | 1 | Return-from-interrupt strobe |
| vec_req_o | output | 1 | Vector-call request to the core |
| vec_addr_o | output | 16 | Vector address of the current request |
| vec_hi_o | output | 1 | Level of the current request |
| pend_clr_o | output | NUM_SRC | One-cycle hardware clear of a pending flag |
| in_svc_o | output | 2 | In-service bits {high, low} |

## Verification
The bench aims at the nesting corners. It tests a high request arriving during a low routine, which must preempt it. It tests requests arriving during a high routine, which must wait; a design that ignored the high in-service bit would nest a third call. It checks the gap after each return: a design that vectored on the first boundary after a return would produce a call one cycle early, and the bench catches that by timing vec_req_o edge by edge. It checks ties inside a level, masking by the source and global enables, and the call held across a delayed acknowledge. A scoreboard compares every call's address, level and clear pulse against the expected order, so a wrong priority or a missing clear pulse shows up as a mismatch.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int unsigned IRQ_ADDR_W = 16;

  typedef enum logic [0:0] {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } irq_lvl_e;
endpackage

// File: rtl/irq_nest_arb.sv
module irq_nest_arb #(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned IW = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] req_lo_i,
  input  logic [NUM_SRC-1:0] req_hi_i,
  output logic               valid_o,
  output logic               hi_o,
  output logic [IW-1:0]      idx_o
);
  // one fixed-order finder per level; index 0 is most urgent
  for (genvar l = 0; l < 2; l++) begin : g_lvl
    logic [NUM_SRC-1:0] req;
    logic               any;
    logic [IW-1:0]      idx;

    assign req = (l == 1) ? req_hi_i : req_lo_i;

    always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
        if (req[i]) begin
          any = 1'b1;
          idx = IW'(i);
        end
      end
    end
  end

  always_comb begin
    valid_o = g_lvl[1].any | g_lvl[0].any;
    hi_o    = g_lvl[1].any;
    idx_o   = g_lvl[1].any ? g_lvl[1].idx : g_lvl[0].idx;
  end
endmodule

// File: rtl/irq_nest_lvl.sv
module irq_nest_lvl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       issue_i,
  input  logic       issue_hi_i,
  input  logic       reti_i,
  input  logic       insn_bnd_i,
  output logic [1:0] in_svc_o,
  output logic       allow_hi_o,
  output logic       allow_lo_o,
  output logic       hold_o
);
  logic [1:0] svc_q;
  logic       gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svc_q <= 2'b00;
    end else if (reti_i) begin
      if (svc_q[1]) svc_q[1] <= 1'b0;
      else          svc_q[0] <= 1'b0;
    end else if (issue_i) begin
      if (issue_hi_i) svc_q[1] <= 1'b1;
      else            svc_q[0] <= 1'b1;
    end
  end

  // blocks vectoring until one instruction completes after a return
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         gap_q <= 1'b0;
    else if (reti_i)     gap_q <= 1'b1;
    else if (insn_bnd_i) gap_q <= 1'b0;
  end

  assign in_svc_o   = svc_q;
  assign allow_hi_o = ~svc_q[1];
  assign allow_lo_o = ~svc_q[1] & ~svc_q[0];
  assign hold_o     = gap_q;
endmodule

// File: rtl/irq_nest_vec.sv
module irq_nest_vec import irq_nest_pkg::*; #(
  parameter int unsigned NUM_SRC    = 8,
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8,
  parameter logic [NUM_SRC-1:0] AUTO_CLR = '0,
  localparam int unsigned IW = $clog2(NUM_SRC)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  issue_i,
  input  logic                  issue_hi_i,
  input  logic [IW-1:0]         issue_idx_i,
  input  logic                  call_done_i,
  output logic                  req_o,
  output logic [IRQ_ADDR_W-1:0] addr_o,
  output logic                  hi_o,
  output logic [NUM_SRC-1:0]    clr_o
);
  logic                  req_q;
  logic [IRQ_ADDR_W-1:0] addr_q;
  irq_lvl_e              lvl_q;
  logic [NUM_SRC-1:0]    clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      lvl_q  <= LVL_LO;
    end else if (issue_i) begin
      req_q  <= 1'b1;
      addr_q <= IRQ_ADDR_W'(VEC_BASE)
              + IRQ_ADDR_W'(VEC_STRIDE) * IRQ_ADDR_W'(issue_idx_i);
      lvl_q  <= issue_hi_i ? LVL_HI : LVL_LO;
    end else if (req_q && call_done_i) begin
      req_q  <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    if (AUTO_CLR[i]) begin : g_on
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) clr_q[i] <= 1'b0;
        else         clr_q[i] <= issue_i && (issue_idx_i == IW'(i));
      end
    end else begin : g_off
      assign clr_q[i] = 1'b0;
    end
  end

  assign req_o  = req_q;
  assign addr_o = addr_q;
  assign hi_o   = (lvl_q == LVL_HI);
  assign clr_o  = clr_q;
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl import irq_nest_pkg::*; #(
  parameter int unsigned NUM_SRC    = 8,
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8,
  parameter logic [NUM_SRC-1:0] AUTO_CLR = NUM_SRC'(5)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  glob_en_i,
  input  logic [NUM_SRC-1:0]    pend_i,
  input  logic [NUM_SRC-1:0]    en_i,
  input  logic [NUM_SRC-1:0]    prio_hi_i,
  input  logic                  insn_bnd_i,
  input  logic                  call_done_i,
  input  logic                  reti_i,
  output logic                  vec_req_o,
  output logic [IRQ_ADDR_W-1:0] vec_addr_o,
  output logic                  vec_hi_o,
  output logic [NUM_SRC-1:0]    pend_clr_o,
  output logic [1:0]            in_svc_o
);
  localparam int unsigned IW = $clog2(NUM_SRC);

  logic               allow_hi, allow_lo, hold;
  logic [NUM_SRC-1:0] elig, req_hi, req_lo;
  logic               arb_valid, arb_hi;
  logic [IW-1:0]      arb_idx;
  logic               cand_valid_q, cand_hi_q;
  logic [IW-1:0]      cand_idx_q;
  logic               cand_live, issue;

  assign elig   = pend_i & en_i & {NUM_SRC{glob_en_i}};
  assign req_hi = elig &  prio_hi_i & {NUM_SRC{allow_hi}};
  assign req_lo = elig & ~prio_hi_i & {NUM_SRC{allow_lo}};

  irq_nest_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .req_lo_i (req_lo),
    .req_hi_i (req_hi),
    .valid_o  (arb_valid),
    .hi_o     (arb_hi),
    .idx_o    (arb_idx)
  );

  // detection stage: winner sampled every cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_valid_q <= 1'b0;
      cand_hi_q    <= 1'b0;
      cand_idx_q   <= '0;
    end else begin
      cand_valid_q <= arb_valid;
      cand_hi_q    <= arb_hi;
      cand_idx_q   <= arb_idx;
    end
  end

  // stale winner (cleared flag, new service level) is dropped here
  assign cand_live = cand_valid_q &&
                     (cand_hi_q ? req_hi[cand_idx_q] : req_lo[cand_idx_q]);
  assign issue = cand_live && insn_bnd_i && !hold && !reti_i && !vec_req_o;

  irq_nest_lvl u_lvl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (issue),
    .issue_hi_i (cand_hi_q),
    .reti_i     (reti_i),
    .insn_bnd_i (insn_bnd_i),
    .in_svc_o   (in_svc_o),
    .allow_hi_o (allow_hi),
    .allow_lo_o (allow_lo),
    .hold_o     (hold)
  );

  irq_nest_vec #(
    .NUM_SRC    (NUM_SRC),
    .VEC_BASE   (VEC_BASE),
    .VEC_STRIDE (VEC_STRIDE),
    .AUTO_CLR   (AUTO_CLR)
  ) u_vec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (issue),
    .issue_hi_i  (cand_hi_q),
    .issue_idx_i (cand_idx_q),
    .call_done_i (call_done_i),
    .req_o       (vec_req_o),
    .addr_o      (vec_addr_o),
    .hi_o        (vec_hi_o),
    .clr_o       (pend_clr_o)
  );
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
  parameter int unsigned NUM_SRC = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               insn_bnd_i,
  input logic               call_done_i,
  input logic               reti_i,
  input logic               vec_req_o,
  input logic [15:0]        vec_addr_o,
  input logic               vec_hi_o,
  input logic [NUM_SRC-1:0] pend_clr_o,
  input logic [1:0]         in_svc_o
);
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_req_o && !call_done_i) |=> (vec_req_o && $stable(vec_addr_o))); // R10
  AST_REQ_AT_BND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_req_o) |-> $past(insn_bnd_i)); // R10
  AST_HI_NO_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_svc_o[1] && !reti_i && !vec_req_o) |=> !vec_req_o); // R7
  AST_RETI_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i |=> !$rose(vec_req_o) ##1 !$rose(vec_req_o)); // R9
  AST_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pend_clr_o)); // R12
  AST_CLR_WITH_CALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pend_clr_o) |-> $rose(vec_req_o)); // R12
  AST_SVC_ON_CALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_req_o) |-> (vec_hi_o ? in_svc_o[1] : in_svc_o[0])); // R6
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .insn_bnd_i  (insn_bnd_i),
  .call_done_i (call_done_i),
  .reti_i      (reti_i),
  .vec_req_o   (vec_req_o),
  .vec_addr_o  (vec_addr_o),
  .vec_hi_o    (vec_hi_o),
  .pend_clr_o  (pend_clr_o),
  .in_svc_o    (in_svc_o)
);

// File: tb/irq_nest_ctrl_tb.sv
module irq_nest_ctrl_tb;
  localparam int unsigned N = 8;
  localparam logic [N-1:0] CLR_MASK = 8'h05;

  typedef struct packed {
    logic [15:0]  addr;
    logic         hi;
    logic [N-1:0] clr;
  } exp_t;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         glob_en_i = 1'b0;
  logic [N-1:0] pend_i = '0;
  logic [N-1:0] en_i = '0;
  logic [N-1:0] prio_hi_i = '0;
  logic         insn_bnd_i = 1'b1;
  logic         call_done_i = 1'b0;
  logic         reti_i = 1'b0;
  logic         vec_req_o;
  logic [15:0]  vec_addr_o;
  logic         vec_hi_o;
  logic [N-1:0] pend_clr_o;
  logic [1:0]   in_svc_o;

  int n_checks = 0;
  int n_errors = 0;
  int n_served = 0;
  int ack_delay = 0;
  exp_t exp_q[$];

  always #2 clk_i = ~clk_i;

  irq_nest_ctrl #(.NUM_SRC(N), .AUTO_CLR(CLR_MASK)) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .glob_en_i   (glob_en_i),
    .pend_i      (pend_i),
    .en_i        (en_i),
    .prio_hi_i   (prio_hi_i),
    .insn_bnd_i  (insn_bnd_i),
    .call_done_i (call_done_i),
    .reti_i      (reti_i),
    .vec_req_o   (vec_req_o),
    .vec_addr_o  (vec_addr_o),
    .vec_hi_o    (vec_hi_o),
    .pend_clr_o  (pend_clr_o),
    .in_svc_o    (in_svc_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input int idx, input bit hi);
    exp_t e;
    e.addr = 16'(3 + 8 * idx);
    e.hi   = hi;
    e.clr  = CLR_MASK[idx] ? N'(1) << idx : '0;
    exp_q.push_back(e);
  endtask

  task automatic wait_served(input int target, input string tag);
    int n = 0;
    while (n_served < target && n < 60) begin
      @(negedge clk_i);
      n++;
    end
    check(n_served >= target, tag, n_served, target);
    @(negedge clk_i);
  endtask

  task automatic quiet(input int cycles, input string tag);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      check(!vec_req_o, tag, vec_req_o, 0);
    end
  endtask

  task automatic do_reti();
    @(negedge clk_i);
    reti_i = 1'b1;
    @(negedge clk_i);
    reti_i = 1'b0;
  endtask

  // peripheral model: honour hardware clear pulses
  always @(negedge clk_i) pend_i = pend_i & ~pend_clr_o;

  // monitor: pop expected call and compare, then acknowledge
  always begin
    @(negedge clk_i);
    if (rst_ni && vec_req_o && !call_done_i) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected call", vec_addr_o, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(vec_addr_o == e.addr, "R2 vector address", vec_addr_o, e.addr);
        check(vec_hi_o == e.hi, "R2 vector level", vec_hi_o, e.hi);
        check(pend_clr_o == e.clr, "R12 clear pulse", pend_clr_o, e.clr);
      end
      for (int i = 0; i < ack_delay; i++) begin
        @(negedge clk_i);
        check(vec_req_o, "R10 request held", vec_req_o, 1);
        check(pend_clr_o == '0, "R12 pulse one cycle", pend_clr_o, 0);
      end
      call_done_i = 1'b1;
      @(negedge clk_i);
      call_done_i = 1'b0;
      n_served++;
    end
  end

  initial begin
    #(4 * 20000);
    check(1'b0, "R10 watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(!vec_req_o, "R1 req reset", vec_req_o, 0);
    check(in_svc_o == 2'b00, "R1 svc reset", in_svc_o, 0);
    check(pend_clr_o == '0, "R1 clr reset", pend_clr_o, 0);
    rst_ni = 1'b1;
    glob_en_i = 1'b1;
    en_i = '1;
    repeat (2) @(negedge clk_i);

    // low request, latency and auto clear
    push_exp(2, 1'b0);
    pend_i[2] = 1'b1;
    @(negedge clk_i);
    check(!vec_req_o, "R13 not after one edge", vec_req_o, 0);
    @(negedge clk_i);
    check(vec_req_o, "R13 rise on second edge", vec_req_o, 1);
    wait_served(1, "R13 served");
    check(in_svc_o == 2'b01, "R6 low in service", in_svc_o, 1);

    // same-level request held
    pend_i[1] = 1'b1;
    quiet(5, "R8 low held under low");

    // high preempts low
    prio_hi_i[5] = 1'b1;
    push_exp(5, 1'b1);
    pend_i[5] = 1'b1;
    wait_served(2, "R6 preempt served");
    check(in_svc_o == 2'b11, "R6 both in service", in_svc_o, 3);
    pend_i[5] = 1'b0;

    // nothing preempts high
    prio_hi_i[3] = 1'b1;
    pend_i[3] = 1'b1;
    quiet(5, "R7 held under high");

    // return: one instruction gap, then high src3
    push_exp(3, 1'b1);
    do_reti();
    check(in_svc_o == 2'b01, "R11 high cleared first", in_svc_o, 1);
    check(!vec_req_o, "R9 no call at return", vec_req_o, 0);
    @(negedge clk_i);
    check(!vec_req_o, "R9 first boundary skipped", vec_req_o, 0);
    @(negedge clk_i);
    check(vec_req_o, "R9 call on second boundary", vec_req_o, 1);
    wait_served(3, "R9 served");
    pend_i[3] = 1'b0;
    do_reti();
    check(in_svc_o == 2'b01, "R11 low remains", in_svc_o, 1);
    quiet(4, "R8 low still held");
    push_exp(1, 1'b0);
    do_reti();
    check(in_svc_o == 2'b00, "R11 low cleared", in_svc_o, 0);
    wait_served(4, "R8 released");
    pend_i[1] = 1'b0;
    do_reti();

    // simultaneous arrivals with boundaries withheld
    insn_bnd_i = 1'b0;
    prio_hi_i[4] = 1'b1;
    prio_hi_i[7] = 1'b1;
    pend_i[4] = 1'b1;
    pend_i[6] = 1'b1;
    pend_i[7] = 1'b1;
    quiet(4, "R10 no call without boundary");
    push_exp(4, 1'b1);
    ack_delay = 3;
    insn_bnd_i = 1'b1;
    wait_served(5, "R3 high first, R4 lowest index");
    ack_delay = 0;
    check(in_svc_o == 2'b10, "R3 high in service", in_svc_o, 2);
    pend_i[4] = 1'b0;
    quiet(4, "R7 second high held");
    push_exp(7, 1'b1);
    do_reti();
    wait_served(6, "R3 next high");
    pend_i[7] = 1'b0;
    push_exp(6, 1'b0);
    do_reti();
    wait_served(7, "R3 low last");
    pend_i[6] = 1'b0;
    do_reti();

    // low-level tie
    push_exp(0, 1'b0);
    pend_i[0] = 1'b1;
    pend_i[1] = 1'b1;
    wait_served(8, "R4 low tie");
    push_exp(1, 1'b0);
    do_reti();
    wait_served(9, "R4 second low");
    pend_i[1] = 1'b0;
    do_reti();

    // masking
    en_i[3] = 1'b0;
    pend_i[3] = 1'b1;
    quiet(6, "R5 source disabled");
    glob_en_i = 1'b0;
    en_i[3] = 1'b1;
    quiet(6, "R5 global disabled");
    check(pend_clr_o == '0, "R5 no clear while masked", pend_clr_o, 0);
    push_exp(3, 1'b1);
    glob_en_i = 1'b1;
    wait_served(10, "R5 enabled later");
    pend_i[3] = 1'b0;
    do_reti();
    repeat (3) @(negedge clk_i);
    check(exp_q.size() == 0, "R2 all calls seen", exp_q.size(), 0);
    check(in_svc_o == 2'b00, "R11 idle at end", in_svc_o, 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule